// File: doc/BRIEF.md
# Transmit Queue Steering Arbiter

This block chooses which transmit queue is served next and reports the prioritized DMA channel that queue feeds. Up to sixteen queues present request bits. A configuration input binds each queue to one of eight channels, and several queues may share a channel. A per-queue enable bit decides whether a queue may compete at all.

The channels have a fixed ranking. The command channel (7) beats every traffic channel. Among the four traffic channels (0 background, 1 best effort, 2 video, 3 voice and management), a higher number wins. Channels 4 to 6 are never served. Within the winning channel, the queues take turns in rotating order.

The result is a registered grant that names the queue and the channel. The grant stays in place until the consumer accepts it. A request routed to one of the unserved channels raises a sticky configuration-error flag.

Top module: `tx_steer_arbiter`

## Requirements
- R1: After reset, `grantValid` and `cfgError` are 0. The rotation state of every channel is set so that the lowest-numbered eligible queue is served first.
- R2: A queue is eligible when its request bit and its enable bit are both 1. Its channel is `qChanMap[3*q+2 : 3*q]`. When no grant is held and an eligible queue exists, a grant appears one clock later. `grantQueue` holds that queue and `grantChan` holds its mapped channel.
- R3: If any eligible queue maps to channel 7, the grant goes to channel 7, whatever traffic channels are also pending.
- R4: With no command channel pending, the highest-numbered pending channel among 0 to 3 wins.
- R5: Within a channel, the next grant goes to the first eligible queue above the channel's last granted queue, wrapping from 15 to 0.
- R6: A queue whose enable bit is 0 is never granted, even with its request bit at 1.
- R7: A queue mapped to channel 4, 5 or 6 is never granted. If such a queue is eligible, `cfgError` is 1 from the next clock on, and it stays 1 until reset.
- R8: While `grantValid` is 1 and `grantAccept` is 0, `grantValid`, `grantQueue` and `grantChan` keep their values, whatever the requests do.
- R9: In a cycle with `grantAccept` at 1, the next grant is chosen from that cycle's inputs. If nothing is eligible, `grantValid` is 0 after the clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqVec | input | 16 | Per-queue request bits |
| qEnable | input | 16 | Per-queue enable bits |
| qChanMap | input | 48 | Per-queue channel number, 3 bits per queue, queue q at bits 3q+2..3q |
| grantAccept | input | 1 | Consumer takes the current grant |
| grantValid | output | 1 | A grant is being offered |
| grantQueue | output | 4 | Queue number of the grant |
| grantChan | output | 3 | Channel number of the grant |
| cfgError | output | 1 | Sticky flag: a request was routed to an unserved channel |

## Verification
The assertions treat `grantAccept` as meaningful only while `grantValid` is 1. They compare a new grant against the request, enable and map values sampled one clock earlier, so those inputs are assumed to change only between clock edges. The bench drives every input on the falling edge to meet this. It randomizes accept pulses whether or not a grant is held. It remaps queues only every few hundred cycles, so that runs of contention within one channel occur.

// File: rtl/tx_steer_pkg.sv
package tx_steer_pkg;
  localparam int DEF_NUM_Q = 16;
  localparam int DEF_NUM_CH = 8;
  localparam int DEF_CMD_CH = 7;
  localparam int DEF_NUM_DATA_CH = 4;

  typedef struct packed {
    logic advancePtr;
  } steerStrobe_t;
endpackage

// File: rtl/tx_steer_datapath.sv
module tx_steer_datapath
  import tx_steer_pkg::*;
#(
  parameter int NUM_Q = DEF_NUM_Q,
  parameter int NUM_CH = DEF_NUM_CH,
  parameter int CMD_CH = DEF_CMD_CH,
  parameter int NUM_DATA_CH = DEF_NUM_DATA_CH,
  localparam int QW = $clog2(NUM_Q),
  localparam int CW = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_Q-1:0]  reqVec,
  input  logic [NUM_Q-1:0]  qEnable,
  input  logic [NUM_Q*CW-1:0] qChanMap,
  input  steerStrobe_t      strobe,
  output logic              pickValid,
  output logic [QW-1:0]     pickQueue,
  output logic [CW-1:0]     pickChan,
  output logic              badReq
);

  logic [NUM_Q-1:0] liveVec;
  logic [NUM_CH-1:0][NUM_Q-1:0] chanElig;
  logic [NUM_CH-1:0] chanHit;
  logic [NUM_CH-1:0][QW-1:0] chanIdx;

  assign liveVec = reqVec & qEnable;

  // Requests routed to a channel that is never served
  always_comb begin
    badReq = 1'b0;
    for (int q = 0; q < NUM_Q; q++) begin
      if (liveVec[q]) begin
        if (!(int'(qChanMap[q*CW +: CW]) == CMD_CH ||
              int'(qChanMap[q*CW +: CW]) < NUM_DATA_CH))
          badReq = 1'b1;
      end
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    always_comb begin
      for (int q = 0; q < NUM_Q; q++)
        chanElig[c][q] = liveVec[q] && (int'(qChanMap[q*CW +: CW]) == c);
    end

    if (c == CMD_CH || c < NUM_DATA_CH) begin : g_served
      logic [QW-1:0] lastQ;
      logic          hit;
      logic [QW-1:0] idx;

      // Rotating search starting just above the last granted queue
      always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int k = 1; k <= NUM_Q; k++) begin
          int cand;
          cand = (int'(lastQ) + k) % NUM_Q;
          if (!hit && chanElig[c][cand]) begin
            hit = 1'b1;
            idx = QW'(cand);
          end
        end
      end

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)
          lastQ <= QW'(NUM_Q - 1);
        else if (strobe.advancePtr && int'(pickChan) == c)
          lastQ <= pickQueue;
      end

      assign chanHit[c] = hit;
      assign chanIdx[c] = idx;
    end else begin : g_unused
      assign chanHit[c] = 1'b0;
      assign chanIdx[c] = '0;
    end
  end

  // Fixed ranking: command channel first, then traffic channels high to low
  always_comb begin
    pickValid = 1'b0;
    pickChan = '0;
    for (int c = 0; c < NUM_DATA_CH; c++) begin
      if (chanHit[c]) begin
        pickValid = 1'b1;
        pickChan = CW'(c);
      end
    end
    if (chanHit[CMD_CH]) begin
      pickValid = 1'b1;
      pickChan = CW'(CMD_CH);
    end
    pickQueue = chanIdx[pickChan];
  end

endmodule

// File: rtl/tx_steer_ctrl.sv
module tx_steer_ctrl
  import tx_steer_pkg::*;
#(
  parameter int NUM_Q = DEF_NUM_Q,
  parameter int NUM_CH = DEF_NUM_CH,
  localparam int QW = $clog2(NUM_Q),
  localparam int CW = $clog2(NUM_CH)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          pickValid,
  input  logic [QW-1:0] pickQueue,
  input  logic [CW-1:0] pickChan,
  input  logic          badReq,
  input  logic          grantAccept,
  output steerStrobe_t  strobe,
  output logic          grantValid,
  output logic [QW-1:0] grantQueue,
  output logic [CW-1:0] grantChan,
  output logic          cfgError
);

  logic canIssue;

  assign canIssue = !grantValid || grantAccept;
  assign strobe.advancePtr = canIssue && pickValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      grantValid <= 1'b0;
      grantQueue <= '0;
      grantChan  <= '0;
    end else if (canIssue) begin
      grantValid <= pickValid;
      if (pickValid) begin
        grantQueue <= pickQueue;
        grantChan  <= pickChan;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      cfgError <= 1'b0;
    else if (badReq)
      cfgError <= 1'b1;
  end

endmodule

// File: rtl/tx_steer_arbiter.sv
module tx_steer_arbiter
  import tx_steer_pkg::*;
#(
  parameter int NUM_Q = DEF_NUM_Q,
  parameter int NUM_CH = DEF_NUM_CH,
  parameter int CMD_CH = DEF_CMD_CH,
  parameter int NUM_DATA_CH = DEF_NUM_DATA_CH,
  localparam int QW = $clog2(NUM_Q),
  localparam int CW = $clog2(NUM_CH)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_Q-1:0]    reqVec,
  input  logic [NUM_Q-1:0]    qEnable,
  input  logic [NUM_Q*CW-1:0] qChanMap,
  input  logic                grantAccept,
  output logic                grantValid,
  output logic [QW-1:0]       grantQueue,
  output logic [CW-1:0]       grantChan,
  output logic                cfgError
);

  steerStrobe_t  strobe;
  logic          pickValid;
  logic [QW-1:0] pickQueue;
  logic [CW-1:0] pickChan;
  logic          badReq;

  tx_steer_datapath #(
    .NUM_Q(NUM_Q), .NUM_CH(NUM_CH), .CMD_CH(CMD_CH), .NUM_DATA_CH(NUM_DATA_CH)
  ) dp_i (
    .clk(clk), .rstN(rstN), .reqVec(reqVec), .qEnable(qEnable),
    .qChanMap(qChanMap), .strobe(strobe), .pickValid(pickValid),
    .pickQueue(pickQueue), .pickChan(pickChan), .badReq(badReq)
  );

  tx_steer_ctrl #(.NUM_Q(NUM_Q), .NUM_CH(NUM_CH)) ctrl_i (
    .clk(clk), .rstN(rstN), .pickValid(pickValid), .pickQueue(pickQueue),
    .pickChan(pickChan), .badReq(badReq), .grantAccept(grantAccept),
    .strobe(strobe), .grantValid(grantValid), .grantQueue(grantQueue),
    .grantChan(grantChan), .cfgError(cfgError)
  );

endmodule

// File: rtl/tx_steer_arbiter_chk.sv
module tx_steer_arbiter_chk #(
  parameter int NUM_Q = 16,
  parameter int NUM_CH = 8,
  parameter int CMD_CH = 7,
  parameter int NUM_DATA_CH = 4,
  localparam int QW = $clog2(NUM_Q),
  localparam int CW = $clog2(NUM_CH)
) (
  input logic                clk,
  input logic                rstN,
  input logic [NUM_Q-1:0]    reqVec,
  input logic [NUM_Q-1:0]    qEnable,
  input logic [NUM_Q*CW-1:0] qChanMap,
  input logic                grantAccept,
  input logic                grantValid,
  input logic [QW-1:0]       grantQueue,
  input logic [CW-1:0]       grantChan,
  input logic                cfgError
);

  logic                prevValid, prevAccept;
  logic [NUM_Q-1:0]    prevLive;
  logic [NUM_Q*CW-1:0] prevMap;
  logic                newGrant, prevCmdPending;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevValid  <= 1'b0;
      prevAccept <= 1'b0;
      prevLive   <= '0;
      prevMap    <= '0;
    end else begin
      prevValid  <= grantValid;
      prevAccept <= grantAccept;
      prevLive   <= reqVec & qEnable;
      prevMap    <= qChanMap;
    end
  end

  assign newGrant = grantValid && (!prevValid || prevAccept);

  always_comb begin
    prevCmdPending = 1'b0;
    for (int q = 0; q < NUM_Q; q++)
      if (prevLive[q] && int'(prevMap[q*CW +: CW]) == CMD_CH)
        prevCmdPending = 1'b1;
  end

  // R8: an unaccepted grant does not move
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    grantValid && !grantAccept |=> grantValid && $stable(grantQueue) && $stable(grantChan));

  // R7: only served channels appear on the grant
  assert_served_chan_R7: assert property (@(posedge clk) disable iff (!rstN)
    grantValid |-> (int'(grantChan) == CMD_CH || int'(grantChan) < NUM_DATA_CH));

  // R7: error flag is sticky
  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    cfgError |=> cfgError);

  // R6 and R2: a fresh grant names a queue that was live and mapped to that channel
  assert_enabled_R6: assert property (@(posedge clk) disable iff (!rstN)
    newGrant |-> prevLive[grantQueue]);

  assert_map_match_R2: assert property (@(posedge clk) disable iff (!rstN)
    newGrant |-> prevMap[grantQueue*CW +: CW] == grantChan);

  // R3: command traffic wins whenever it was pending
  assert_cmd_first_R3: assert property (@(posedge clk) disable iff (!rstN)
    newGrant && prevCmdPending |-> int'(grantChan) == CMD_CH);

endmodule

bind tx_steer_arbiter tx_steer_arbiter_chk #(
  .NUM_Q(NUM_Q), .NUM_CH(NUM_CH), .CMD_CH(CMD_CH), .NUM_DATA_CH(NUM_DATA_CH)
) chk_i (
  .clk(clk), .rstN(rstN), .reqVec(reqVec), .qEnable(qEnable),
  .qChanMap(qChanMap), .grantAccept(grantAccept), .grantValid(grantValid),
  .grantQueue(grantQueue), .grantChan(grantChan), .cfgError(cfgError)
);

// File: tb/tx_steer_arbiter_tb_top.sv
module tx_steer_arbiter_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] reqVec = '0;
  logic [15:0] qEnable = '1;
  logic [47:0] qChanMap = '0;
  logic        grantAccept = 1'b0;
  logic        grantValid;
  logic [3:0]  grantQueue;
  logic [2:0]  grantChan;
  logic        cfgError;

  int nChecks = 0;
  int nErrors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tx_steer_arbiter dut_i (
    .clk(clk), .rstN(rstN), .reqVec(reqVec), .qEnable(qEnable),
    .qChanMap(qChanMap), .grantAccept(grantAccept), .grantValid(grantValid),
    .grantQueue(grantQueue), .grantChan(grantChan), .cfgError(cfgError)
  );

  task automatic chk(string tag, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nErrors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit mValid, mErr;
  int mQ, mCh;
  int mLast[8];

  function automatic int mapOf(int q);
    return int'(qChanMap[q*3 +: 3]);
  endfunction

  function automatic bit eligible(int q, int c);
    return reqVec[q] && qEnable[q] && mapOf(q) == c;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mValid <= 0; mErr <= 0; mQ <= 0; mCh <= 0;
      for (int c = 0; c < 8; c++) mLast[c] <= 15;
    end else begin
      int order[5];
      int selCh;
      int selQ;
      order = '{7, 3, 2, 1, 0};
      for (int q = 0; q < 16; q++)
        if (reqVec[q] && qEnable[q] && mapOf(q) >= 4 && mapOf(q) <= 6) mErr <= 1;
      if (!mValid || grantAccept) begin
        selCh = -1;
        selQ = -1;
        foreach (order[i]) begin
          if (selCh < 0)
            for (int q = 0; q < 16; q++)
              if (eligible(q, order[i])) selCh = order[i];
        end
        if (selCh >= 0) begin
          for (int k = 1; k <= 16; k++)
            if (selQ < 0 && eligible((mLast[selCh] + k) % 16, selCh))
              selQ = (mLast[selCh] + k) % 16;
          mValid <= 1; mQ <= selQ; mCh <= selCh; mLast[selCh] <= selQ;
        end else begin
          mValid <= 0;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rstN && !done) begin
      chk("R8 R9 model grantValid", int'(grantValid), int'(mValid));
      if (mValid) begin
        chk("R2 R5 model grantQueue", int'(grantQueue), mQ);
        chk("R3 R4 model grantChan", int'(grantChan), mCh);
      end
      chk("R7 model cfgError", int'(cfgError), int'(mErr));
    end
  end

  // ---------------- stimulus ----------------
  task automatic step(int n);
    repeat (n) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic acceptOnce();
    grantAccept = 1'b1;
    step(1);
    grantAccept = 1'b0;
  endtask

  task automatic defaultMap();
    for (int q = 0; q < 16; q++)
      qChanMap[q*3 +: 3] = (q >= 12) ? 3'd7 : 3'(q % 4);
  endtask

  initial begin
    defaultMap();
    qEnable = '1;
    step(2);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 reset grantValid", int'(grantValid), 0);
    chk("R1 reset cfgError", int'(cfgError), 0);

    reqVec = 16'h0020;                  // q5 on ch1
    step(1);
    chk("R2 grantValid", int'(grantValid), 1);
    chk("R2 grantQueue", int'(grantQueue), 5);
    chk("R2 grantChan", int'(grantChan), 1);

    reqVec = 16'h2000;                  // q13 on ch7, no accept
    step(3);
    chk("R8 held queue", int'(grantQueue), 5);
    chk("R8 held chan", int'(grantChan), 1);

    reqVec = 16'h200C;                  // q13 ch7, q2 ch2, q3 ch3
    acceptOnce();
    chk("R3 cmd queue", int'(grantQueue), 13);
    chk("R3 cmd chan", int'(grantChan), 7);

    reqVec = 16'h000D;                  // ch0, ch2, ch3
    acceptOnce();
    chk("R4 top traffic chan", int'(grantChan), 3);

    reqVec = 16'h0222;                  // q1, q5, q9 all on ch1; last was q5
    acceptOnce();
    chk("R5 rotate to q9", int'(grantQueue), 9);
    acceptOnce();
    chk("R5 wrap to q1", int'(grantQueue), 1);
    acceptOnce();
    chk("R5 rotate to q5", int'(grantQueue), 5);

    qEnable = 16'hDFFF;                 // disable q13
    reqVec = 16'h2001;
    acceptOnce();
    chk("R6 disabled skipped queue", int'(grantQueue), 0);
    chk("R6 disabled skipped chan", int'(grantChan), 0);
    qEnable = '1;

    reqVec = '0;
    acceptOnce();
    chk("R9 idle drop", int'(grantValid), 0);
    chk("R7 no error yet", int'(cfgError), 0);

    qChanMap[6*3 +: 3] = 3'd5;          // q6 to unserved ch5
    reqVec = 16'h0040;
    step(1);
    chk("R7 unserved not granted", int'(grantValid), 0);
    chk("R7 error raised", int'(cfgError), 1);
    reqVec = '0;
    defaultMap();
    step(2);
    chk("R7 error sticky", int'(cfgError), 1);

    rstN = 1'b0;
    step(1);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 reset clears error", int'(cfgError), 0);

    // random phase, model compared every cycle
    for (int cyc = 0; cyc < 3000; cyc++) begin
      if (cyc % 300 == 0) begin
        for (int q = 0; q < 16; q++) begin
          int r;
          r = $urandom_range(0, 19);
          qChanMap[q*3 +: 3] = (r < 4) ? 3'(r) : (r < 8) ? 3'd7 :
                               (r == 19 && cyc >= 1500) ? 3'd5 : 3'(q % 4);
        end
        qEnable = 16'($urandom) | 16'($urandom);
      end
      reqVec = 16'($urandom) & 16'($urandom);
      grantAccept = ($urandom_range(0, 2) != 0);
      step(1);
    end
    grantAccept = 1'b0;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", nChecks, nErrors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    done = 1;
    nChecks++;
    nErrors++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", nChecks, nErrors);
    $finish;
  end

endmodule